// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches a group of external input pins and turns each one into a clean, debounced level. Each pin is first brought into the system clock domain through a short chain of flip-flops. It is then filtered by a per-channel counter that counts shared millisecond ticks. The ticks come from a prescaler that divides the system clock. A channel's filtered level moves to the new pin value only after the pin has held that value for the channel's programmed number of ticks.

Each channel can raise an interrupt while its filtered level matches a programmed polarity. A capture needs both an enable bit and a one-shot arm bit. When a capture happens, the hardware drops the arm bit. Software then sees one event per arming, even if the level stays active. The captured bits are combined into a single interrupt line. Software acknowledges an event by writing ones to an acknowledge register.

Software reaches the block through a plain word-wide register port. Writes take effect on the next clock edge. Reads return data combinationally.

Top module: `dbnc_irq_bank`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low. This covers the level view (0x00), visibility gate (0x04), polarity (0x14), enable (0x18), captured (0x1C), pending (0x20), arm (0x28) and all window words.
- R2: Each pin passes through a two-flop synchronizer. The filtered level takes the synchronized value only after that value has differed from it for the channel's programmed count of tick pulses. A pulse shorter than that leaves the filtered level unchanged.
- R3: A window value of 0 behaves the same as a window value of 1.
- R4: At 0x00, bit n returns channel n's filtered level ANDed with bit n of the visibility gate at 0x04. A gate bit of 0 makes that data bit read 0.
- R5: A channel captures an event into the captured register (0x1C) when its filtered level equals its polarity bit at 0x14. A polarity bit of 1 selects a high level and 0 selects a low level. The capture also needs the channel's enable bit (0x18) and arm bit (0x28) to be 1.
- R6: A capture clears that channel's arm bit. While the arm bit is 0, a level that stays active causes no new capture. Writing the arm bit to 1 again allows a new capture.
- R7: Writing 1 to bit n of the acknowledge address 0x24 clears captured bit n. Writing 0 leaves it unchanged.
- R8: The pending register (0x20) reads as the captured bits ANDed with the enable bits. `irq_out` is high exactly when any pending bit is 1.
- R9: A channel with its enable bit or its arm bit at 0 does not capture. The arm bit keeps the value software wrote.
- R10: Channel n's window lives in bits [11:0] of the word at 0x40 + 4*n. Each channel's window is stored independently. Upper write bits are dropped and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw external inputs, one per channel, asynchronous to `clk` |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt, high while any pending bit is set |

## Verification
The assertions rely on three assumptions about the inputs. The register port is driven only with `reg_wr` and its address and data settled around each rising edge. Filtered levels move only in the cycle after a tick pulse. A captured bit can only appear where the arm and enable bits were set in the cycle before.

The stimulus meets these assumptions in the following ways:
- Every write is driven on the falling edge and held for one full cycle.
- Pin changes are applied on the falling edge. The synchronizer chain is exercised without metastability.
- Level checks are placed well before the earliest possible filter expiry or well after the latest one. This keeps them independent of where the tick phase falls.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
   // Register byte offsets seen by software
   localparam logic [7:0] OFS_LEVEL = 8'h00;
   localparam logic [7:0] OFS_GATE  = 8'h04;
   localparam logic [7:0] OFS_POL   = 8'h14;
   localparam logic [7:0] OFS_IEN   = 8'h18;
   localparam logic [7:0] OFS_RAW   = 8'h1C;
   localparam logic [7:0] OFS_PEND  = 8'h20;
   localparam logic [7:0] OFS_ACK   = 8'h24;
   localparam logic [7:0] OFS_ARM   = 8'h28;
   localparam logic [7:0] OFS_WIN   = 8'h40;

   // Decoded register target
   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_LEVEL,
      SEL_GATE,
      SEL_POL,
      SEL_IEN,
      SEL_RAW,
      SEL_PEND,
      SEL_ACK,
      SEL_ARM,
      SEL_WIN
   } reg_sel_e;
endpackage

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
   parameter int unsigned TICK_DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   if (TICK_DIV < 1) begin : g_bad_div
      $error("dbnc_tick_gen: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_every_cycle
      // Each clock is one tick: no counter needed
      assign tick_o = rst_n;
   end else begin : g_divider
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (div_q == LAST) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end

      assign tick_o = (div_q == LAST);
   end
endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] win_i,
   output logic             level_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dbnc_chan: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("dbnc_chan: CNT_W must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic [CNT_W-1:0]       limit;
   logic [CNT_W-1:0]       cnt_q;
   logic                   expire;
   logic                   level_q;

   // Synchronizer chain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
   end
   assign synced = sync_q[SYNC_STAGES-1];

   // Window of zero counts as one tick
   assign limit  = (win_i == '0) ? CNT_W'(1) : win_i;
   assign expire = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

   // Count ticks only while the synchronized input disagrees with the filtered level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         level_q <= 1'b0;
      end else if (synced == level_q) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (expire) begin
            level_q <= synced;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign level_o = level_q;
endmodule

// File: rtl/dbnc_irq_ctrl.sv
module dbnc_irq_ctrl #(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] level_i,
   input  logic [NUM_CH-1:0] pol_i,
   input  logic [NUM_CH-1:0] ien_i,
   input  logic              arm_wr_i,
   input  logic [NUM_CH-1:0] arm_wdata_i,
   input  logic              ack_wr_i,
   input  logic [NUM_CH-1:0] ack_mask_i,
   output logic [NUM_CH-1:0] raw_o,
   output logic [NUM_CH-1:0] arm_o,
   output logic [NUM_CH-1:0] pend_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] raw_q;
   logic [NUM_CH-1:0] arm_q;
   logic [NUM_CH-1:0] capture;
   logic [NUM_CH-1:0] raw_d;
   logic [NUM_CH-1:0] arm_d;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      // Active when the filtered level equals the polarity bit
      assign capture[n] = ~(level_i[n] ^ pol_i[n]) & ien_i[n] & arm_q[n];
      // A capture in the same cycle beats an acknowledge
      assign raw_d[n]   = (raw_q[n] & ~(ack_wr_i & ack_mask_i[n])) | capture[n];
      // A capture disarms the channel, even against a simultaneous write
      assign arm_d[n]   = (arm_wr_i ? arm_wdata_i[n] : arm_q[n]) & ~capture[n];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         arm_q <= '0;
      end else begin
         raw_q <= raw_d;
         arm_q <= arm_d;
      end
   end

   assign raw_o  = raw_q;
   assign arm_o  = arm_q;
   assign pend_o = raw_q & ien_i;
   assign irq_o  = |pend_o;
endmodule

// File: rtl/dbnc_regfile.sv
module dbnc_regfile
   import dbnc_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic                         wr_i,
   input  logic [DATA_W-1:0]            wdata_i,
   output logic [DATA_W-1:0]            rdata_o,
   input  logic [NUM_CH-1:0]            level_i,
   input  logic [NUM_CH-1:0]            raw_i,
   input  logic [NUM_CH-1:0]            arm_i,
   input  logic [NUM_CH-1:0]            pend_i,
   output logic [NUM_CH-1:0]            pol_o,
   output logic [NUM_CH-1:0]            ien_o,
   output logic [NUM_CH-1:0][CNT_W-1:0] win_o,
   output logic                         arm_wr_o,
   output logic                         ack_wr_o,
   output logic [NUM_CH-1:0]            bits_o
);
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic [NUM_CH-1:0]            gate_q;
   logic [NUM_CH-1:0]            pol_q;
   logic [NUM_CH-1:0]            ien_q;
   logic [NUM_CH-1:0][CNT_W-1:0] win_q;
   reg_sel_e                     sel;
   logic [ADDR_W-1:0]            win_off;
   logic [IDX_W-1:0]             win_idx;

   // Address decode
   assign win_off = addr_i - ADDR_W'(OFS_WIN);
   assign win_idx = win_off[IDX_W+1:2];

   always_comb begin
      sel = SEL_NONE;
      if (addr_i == ADDR_W'(OFS_LEVEL))     sel = SEL_LEVEL;
      else if (addr_i == ADDR_W'(OFS_GATE)) sel = SEL_GATE;
      else if (addr_i == ADDR_W'(OFS_POL))  sel = SEL_POL;
      else if (addr_i == ADDR_W'(OFS_IEN))  sel = SEL_IEN;
      else if (addr_i == ADDR_W'(OFS_RAW))  sel = SEL_RAW;
      else if (addr_i == ADDR_W'(OFS_PEND)) sel = SEL_PEND;
      else if (addr_i == ADDR_W'(OFS_ACK))  sel = SEL_ACK;
      else if (addr_i == ADDR_W'(OFS_ARM))  sel = SEL_ARM;
      else if ((addr_i >= ADDR_W'(OFS_WIN)) && (addr_i[1:0] == 2'b00) &&
               ((win_off >> 2) < ADDR_W'(NUM_CH)))
         sel = SEL_WIN;
   end

   // Writable control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= '0;
         pol_q  <= '0;
         ien_q  <= '0;
      end else if (wr_i) begin
         case (sel)
            SEL_GATE: gate_q <= wdata_i[NUM_CH-1:0];
            SEL_POL:  pol_q  <= wdata_i[NUM_CH-1:0];
            SEL_IEN:  ien_q  <= wdata_i[NUM_CH-1:0];
            default:  ;
         endcase
      end
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q[n] <= '0;
         end else if (wr_i && (sel == SEL_WIN) && (win_idx == IDX_W'(n))) begin
            win_q[n] <= wdata_i[CNT_W-1:0];
         end
      end
   end

   // Strobes for state owned by the interrupt logic
   assign arm_wr_o = wr_i && (sel == SEL_ARM);
   assign ack_wr_o = wr_i && (sel == SEL_ACK);
   assign bits_o   = wdata_i[NUM_CH-1:0];

   // Read mux
   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_LEVEL: rdata_o[NUM_CH-1:0] = level_i & gate_q;
         SEL_GATE:  rdata_o[NUM_CH-1:0] = gate_q;
         SEL_POL:   rdata_o[NUM_CH-1:0] = pol_q;
         SEL_IEN:   rdata_o[NUM_CH-1:0] = ien_q;
         SEL_RAW:   rdata_o[NUM_CH-1:0] = raw_i;
         SEL_PEND:  rdata_o[NUM_CH-1:0] = pend_i;
         SEL_ARM:   rdata_o[NUM_CH-1:0] = arm_i;
         SEL_WIN:   rdata_o[CNT_W-1:0]  = win_q[win_idx];
         default:   rdata_o = '0;
      endcase
   end

   assign pol_o = pol_q;
   assign ien_o = ien_q;
   assign win_o = win_q;
endmodule

// File: rtl/dbnc_irq_bank.sv
module dbnc_irq_bank #(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TICK_DIV    = 250000,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_in,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);
   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("dbnc_irq_bank: NUM_CH must lie in 1..DATA_W");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("dbnc_irq_bank: CNT_W must not exceed DATA_W");
   end
   if ((64 + 4 * NUM_CH) > (1 << ADDR_W)) begin : g_bad_addr
      $error("dbnc_irq_bank: window words do not fit in ADDR_W");
   end

   logic                         tick_w;
   logic [NUM_CH-1:0]            level_w;
   logic [NUM_CH-1:0]            pol_w;
   logic [NUM_CH-1:0]            ien_w;
   logic [NUM_CH-1:0][CNT_W-1:0] win_w;
   logic [NUM_CH-1:0]            raw_w;
   logic [NUM_CH-1:0]            arm_w;
   logic [NUM_CH-1:0]            pend_w;
   logic                         arm_wr_w;
   logic                         ack_wr_w;
   logic [NUM_CH-1:0]            bits_w;

   dbnc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick_w)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      dbnc_chan #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_i   (pin_in[n]),
         .tick_i  (tick_w),
         .win_i   (win_w[n]),
         .level_o (level_w[n])
      );
   end

   dbnc_irq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .level_i     (level_w),
      .pol_i       (pol_w),
      .ien_i       (ien_w),
      .arm_wr_i    (arm_wr_w),
      .arm_wdata_i (bits_w),
      .ack_wr_i    (ack_wr_w),
      .ack_mask_i  (bits_w),
      .raw_o       (raw_w),
      .arm_o       (arm_w),
      .pend_o      (pend_w),
      .irq_o       (irq_out)
   );

   dbnc_regfile #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (reg_addr),
      .wr_i     (reg_wr),
      .wdata_i  (reg_wdata),
      .rdata_o  (reg_rdata),
      .level_i  (level_w),
      .raw_i    (raw_w),
      .arm_i    (arm_w),
      .pend_i   (pend_w),
      .pol_o    (pol_w),
      .ien_o    (ien_w),
      .win_o    (win_w),
      .arm_wr_o (arm_wr_w),
      .ack_wr_o (ack_wr_w),
      .bits_o   (bits_w)
   );
endmodule

// File: rtl/dbnc_irq_bank_chk.sv
module dbnc_irq_bank_chk #(
   parameter int unsigned NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [NUM_CH-1:0] level,
   input logic [NUM_CH-1:0] raw,
   input logic [NUM_CH-1:0] arm,
   input logic [NUM_CH-1:0] ien,
   input logic              irq_out
);
   // Filtered levels move only right after a tick pulse
   assert_level_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level) |-> $past(tick));

   // Combined line follows the enabled captured bits
   assert_irq_follows_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == ((raw & ien) != '0));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
      // A new capture needs arm and enable in the cycle before
      assert_capture_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(raw[n]) |-> $past(arm[n] && ien[n]));

      // A new capture leaves the channel disarmed
      assert_capture_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(raw[n]) |-> !arm[n]);
   end
endmodule

bind dbnc_irq_bank dbnc_irq_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_w),
   .level   (level_w),
   .raw     (raw_w),
   .arm     (arm_w),
   .ien     (ien_w),
   .irq_out (irq_out)
);

// File: tb/dbnc_irq_bank_tb_top.sv
module dbnc_irq_bank_tb_top;
   localparam int unsigned DIV = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin_in = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dbnc_irq_bank #(.TICK_DIV(DIV)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_out   (irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(8'h00, v); check("R1 level", v, 0);
      rd(8'h04, v); check("R1 gate", v, 0);
      rd(8'h1C, v); check("R1 raw", v, 0);
      rd(8'h28, v); check("R1 arm", v, 0);
      rd(8'h40, v); check("R1 window", v, 0);
      check("R1 irq_out", 32'(irq_out), 0);
   endtask

   task automatic t_windows;
      logic [31:0] v;
      for (int n = 0; n < 8; n++) wr(8'(8'h40 + 4 * n), 32'hFFFF_F000 | 32'(n * 100 + 7));
      for (int n = 0; n < 8; n++) begin
         rd(8'(8'h40 + 4 * n), v);
         check("R10 window readback", v, 32'(n * 100 + 7));
      end
   endtask

   task automatic t_debounce;
      logic [31:0] v;
      wr(8'h40, 32'd4);
      wr(8'h44, 32'd4);
      wr(8'h48, 32'd0);
      wr(8'h04, 32'hFF);
      @(negedge clk);
      pin_in[0] = 1'b1;
      wait_cyc(28);
      rd(8'h00, v); check("R2 held before window", v & 1, 0);
      wait_cyc(16);
      rd(8'h00, v); check("R2 level after window", v & 1, 1);
      wr(8'h04, 32'hFE);
      rd(8'h00, v); check("R4 gated bit reads 0", v & 1, 0);
      wr(8'h04, 32'hFF);
      rd(8'h00, v); check("R4 ungated bit reads level", v & 1, 1);
   endtask

   task automatic t_glitch;
      logic [31:0] v;
      @(negedge clk);
      pin_in[1] = 1'b1;
      wait_cyc(20);
      pin_in[1] = 1'b0;
      wait_cyc(60);
      rd(8'h00, v); check("R2 short pulse rejected", (v >> 1) & 1, 0);
   endtask

   task automatic t_zero_window;
      logic [31:0] v;
      @(negedge clk);
      pin_in[2] = 1'b1;
      wait_cyc(15);
      rd(8'h00, v); check("R3 zero window acts as one", (v >> 2) & 1, 1);
   endtask

   task automatic t_capture_high;
      logic [31:0] v;
      wr(8'h14, 32'h01);
      wr(8'h18, 32'h01);
      wr(8'h28, 32'h01);
      wait_cyc(2);
      rd(8'h1C, v); check("R5 high capture", v, 32'h01);
      rd(8'h28, v); check("R6 arm cleared", v, 0);
      rd(8'h20, v); check("R8 pending", v, 32'h01);
      check("R8 irq_out high", 32'(irq_out), 1);
      wr(8'h24, 32'h00);
      rd(8'h1C, v); check("R7 zero ack ignored", v, 32'h01);
      wr(8'h24, 32'h01);
      wait_cyc(3);
      rd(8'h1C, v); check("R6 R7 cleared, no recapture", v, 0);
      check("R8 irq_out low", 32'(irq_out), 0);
      wr(8'h28, 32'h01);
      wait_cyc(2);
      rd(8'h1C, v); check("R6 rearm recaptures", v, 32'h01);
      wr(8'h24, 32'hFF);
   endtask

   task automatic t_capture_low;
      logic [31:0] v;
      wr(8'h18, 32'h09);
      wr(8'h28, 32'h08);
      wait_cyc(2);
      rd(8'h1C, v); check("R5 low capture", v, 32'h08);
      wr(8'h24, 32'hFF);
      rd(8'h1C, v); check("R7 clear all", v, 0);
   endtask

   task automatic t_gating;
      logic [31:0] v;
      wr(8'h28, 32'h10);
      wait_cyc(3);
      rd(8'h1C, v); check("R9 no capture without enable", v, 0);
      rd(8'h28, v); check("R9 arm kept", v, 32'h10);
      wr(8'h28, 32'h00);
      wr(8'h18, 32'h19);
      wait_cyc(3);
      rd(8'h1C, v); check("R9 no capture without arm", v, 0);
      wr(8'h28, 32'h10);
      wait_cyc(2);
      rd(8'h20, v); check("R8 pending with enable", v, 32'h10);
      check("R8 irq_out high ch4", 32'(irq_out), 1);
      wr(8'h18, 32'h09);
      rd(8'h1C, v); check("R8 raw kept", v, 32'h10);
      rd(8'h20, v); check("R8 pending masked", v, 0);
      check("R8 irq_out masked", 32'(irq_out), 0);
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      t_reset();
      t_windows();
      t_debounce();
      t_glitch();
      t_zero_window();
      t_capture_high();
      t_capture_low();
      t_gating();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule